// File: doc/BRIEF.md
# Filtered Performance Event Counter

This block is one programmable performance-monitoring counter. Every clock it receives a small count of how many times some event occurred in that cycle, together with the current 2-bit privilege level. It first decides whether the cycle is eligible: privilege level 0 is the kernel level, and levels 1, 2 and 3 are the user level. It then turns the occurrence count into an increment. The increment can be the raw count, a one-bit threshold result, the inverse of that result, or a rising-edge pulse of the result. The increment is added to a wide accumulator that wraps around and records a sticky overflow.

Software programs the counter in two ways. It writes a 13-bit configuration word over a valid/data port. It can also load the accumulator directly over a second valid/data port, and a load clears the overflow flag. The accumulator value and the overflow flag are registered outputs.

Configuration word layout: bit 0 user enable, bit 1 kernel enable, bit 2 edge mode, bit 3 invert, bit 4 global enable, bits 12:5 threshold (0 to 255).

Top module: `perf_event_counter`

## Requirements
- R1: After reset, `cnt_value` is 0, `overflow` is 0 and the configuration is all zero. With that configuration the counter does not move for any input.
- R2: Configuration bit 0 (user enable) permits counting in cycles where `priv_lvl` is 1, 2 or 3. Cycles at those levels add nothing when the bit is clear.
- R3: Configuration bit 1 (kernel enable) permits counting in cycles where `priv_lvl` is 0. Cycles at level 0 add nothing when the bit is clear.
- R4: With threshold 0, invert clear and edge clear, each eligible cycle adds the raw value of `evt_count` to the accumulator.
- R5: With a threshold of 1 or more and invert clear, each eligible cycle adds 1 when `evt_count` is greater than or equal to the threshold, and adds 0 otherwise.
- R6: With invert (bit 3) set, each eligible cycle adds 1 when the condition is not met and adds 0 when it is met. With a nonzero threshold the condition is `evt_count >= threshold`. With threshold 0 the condition is `evt_count != 0`.
- R7: With edge (bit 2) set and a nonzero threshold, an eligible cycle adds 1 only when the condition (after any invert) holds in this cycle and did not hold in the previous cycle. The previous-condition state reads as "not met" after any configuration write and after any cycle with the global enable clear.
- R8: With edge set and threshold 0, the counter adds nothing, whatever the other inputs are.
- R9: With the global enable (bit 4) clear, the counter adds nothing.
- R10: A configuration write on `cfg_valid` takes effect from the next cycle. A counter write on `cnt_wr_valid` loads `cnt_wr_data` at the next clock, overrides any increment in that cycle, and clears `overflow`.
- R11: The 48-bit accumulator wraps modulo 2^48. A wrap sets `overflow`, and `overflow` stays set until the next counter write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_data | input | 13 | Configuration word |
| cnt_wr_valid | input | 1 | Counter load strobe |
| cnt_wr_data | input | 48 | Counter load value |
| evt_count | input | 4 | Event occurrences in this cycle |
| priv_lvl | input | 2 | Current privilege level |
| cnt_value | output | 48 | Accumulator value (registered) |
| overflow | output | 1 | Sticky wrap flag (registered) |

## Verification
Every increment is visible at `cnt_value` one clock after the inputs that caused it. A wrong threshold compare, a wrong privilege decision or a wrong invert therefore shows up as a count difference on the very next sample. A stale edge-detector state is harder to see. It only shows when the first qualifying cycle after a configuration write, or after a disabled cycle, adds the wrong amount, so the stimulus places such cycles right after those events. A bad overflow path shows when `overflow` differs from the carry of the add in the wrapping cycle, and it stays wrong until the next counter load.

// File: rtl/pec_pkg.sv
package pec_pkg;

  localparam int MASK_W = 8;

  typedef struct packed {
    logic [MASK_W-1:0] thresh;    // [12:5]
    logic              enable;    // [4]
    logic              invert;    // [3]
    logic              edge_det;  // [2]
    logic              kern_en;   // [1]
    logic              user_en;   // [0]
  } pec_cfg_t;

  localparam int CFG_W = $bits(pec_cfg_t);

endpackage

// File: rtl/pec_priv_gate.sv
module pec_priv_gate (
  input  logic       enable,
  input  logic       user_en,
  input  logic       kern_en,
  input  logic [1:0] priv_lvl,
  output logic       eligible
);

  logic at_kernel;

  always_comb begin
    at_kernel = (priv_lvl == 2'd0);
    eligible  = enable & (at_kernel ? kern_en : user_en);
  end

endmodule

// File: rtl/pec_cond_unit.sv
module pec_cond_unit #(
  parameter int EVT_W  = 4,
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_prev,
  input  logic              eligible,
  input  logic [EVT_W-1:0]  evt,
  input  logic [MASK_W-1:0] thresh,
  input  logic              invert,
  input  logic              edge_det,
  output logic [EVT_W-1:0]  inc
);

  localparam int CMP_W = (EVT_W > MASK_W) ? EVT_W : MASK_W;

  logic [CMP_W-1:0] evt_ext;
  logic [CMP_W-1:0] thr_ext;
  logic             mask_zero;
  logic             met;
  logic             lvl;
  logic             raw_mode;
  logic             prev_q;

  always_comb begin
    evt_ext   = CMP_W'(evt);
    thr_ext   = CMP_W'(thresh);
    mask_zero = (thresh == '0);
    met       = mask_zero ? (evt != '0) : (evt_ext >= thr_ext);
    lvl       = met ^ invert;
    raw_mode  = mask_zero & ~invert & ~edge_det;
  end

  always_comb begin
    inc = '0;
    if (eligible) begin
      if (edge_det) begin
        if (!mask_zero && lvl && !prev_q) inc = EVT_W'(1);
      end else if (raw_mode) begin
        inc = evt;
      end else if (lvl) begin
        inc = EVT_W'(1);
      end
    end
  end

  // The previous-condition state follows the filtered condition.
  always_ff @(posedge clk) begin
    if (rst || clr_prev) prev_q <= 1'b0;
    else                 prev_q <= eligible & lvl;
  end

endmodule

// File: rtl/pec_accum.sv
module pec_accum #(
  parameter int CNT_W = 48,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);

  logic [CNT_W:0] sum_w;

  always_comb begin
    sum_w = {1'b0, cnt_q} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (wr_valid) begin
      cnt_q <= wr_data;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= sum_w[CNT_W-1:0];
      ovf_q <= ovf_q | sum_w[CNT_W];
    end
  end

endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter #(
  parameter int EVT_W = 4,
  parameter int CNT_W = 48
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_valid,
  input  logic [pec_pkg::CFG_W-1:0] cfg_data,
  input  logic                     cnt_wr_valid,
  input  logic [CNT_W-1:0]         cnt_wr_data,
  input  logic [EVT_W-1:0]         evt_count,
  input  logic [1:0]               priv_lvl,
  output logic [CNT_W-1:0]         cnt_value,
  output logic                     overflow
);

  import pec_pkg::*;

  pec_cfg_t         cfg_q;
  logic             eligible;
  logic             clr_prev;
  logic [EVT_W-1:0] inc;

  always_ff @(posedge clk) begin
    if (rst)            cfg_q <= '0;
    else if (cfg_valid) cfg_q <= pec_cfg_t'(cfg_data);
  end

  assign clr_prev = cfg_valid | ~cfg_q.enable;

  pec_priv_gate u_gate (
    .enable   (cfg_q.enable),
    .user_en  (cfg_q.user_en),
    .kern_en  (cfg_q.kern_en),
    .priv_lvl (priv_lvl),
    .eligible (eligible)
  );

  pec_cond_unit #(.EVT_W(EVT_W), .MASK_W(MASK_W)) u_cond (
    .clk      (clk),
    .rst      (rst),
    .clr_prev (clr_prev),
    .eligible (eligible),
    .evt      (evt_count),
    .thresh   (cfg_q.thresh),
    .invert   (cfg_q.invert),
    .edge_det (cfg_q.edge_det),
    .inc      (inc)
  );

  pec_accum #(.CNT_W(CNT_W), .INC_W(EVT_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (cnt_wr_valid),
    .wr_data  (cnt_wr_data),
    .inc      (inc),
    .cnt_q    (cnt_value),
    .ovf_q    (overflow)
  );

endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
  parameter int EVT_W = 4,
  parameter int CNT_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_wr_valid,
  input logic [CNT_W-1:0]  cnt_wr_data,
  input pec_pkg::pec_cfg_t cfg_q,
  input logic [CNT_W-1:0]  cnt_value,
  input logic              overflow
);

  localparam logic [CNT_W-1:0] MAX_INC = CNT_W'((1 << EVT_W) - 1);

  logic [CNT_W-1:0] last_val;
  logic [CNT_W-1:0] delta;

  always_ff @(posedge clk) last_val <= cnt_value;
  assign delta = cnt_value - last_val;

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_valid |=> cnt_value == $past(cnt_wr_data));                      // R10
  AST_LOAD_CLEARS_OVF: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_valid |=> !overflow);                                            // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overflow && !cnt_wr_valid) |=> overflow);                              // R11
  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    ($rose(overflow) && !$past(cnt_wr_valid)) |-> cnt_value < last_val);    // R11
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr_valid |=> delta <= MAX_INC);                                    // R4
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q.enable && !cnt_wr_valid) |=> delta == '0);                      // R9
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.edge_det && !cnt_wr_valid) |=> delta <= CNT_W'(1));              // R7
  AST_EDGE_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.edge_det && cfg_q.thresh == '0 && !cnt_wr_valid) |=> delta == '0); // R8

endmodule

bind perf_event_counter pec_checker #(.EVT_W(EVT_W), .CNT_W(CNT_W)) u_pec_chk (
  .clk          (clk),
  .rst          (rst),
  .cnt_wr_valid (cnt_wr_valid),
  .cnt_wr_data  (cnt_wr_data),
  .cfg_q        (cfg_q),
  .cnt_value    (cnt_value),
  .overflow     (overflow)
);

// File: tb/perf_event_counter_bench.sv
module perf_event_counter_bench;

  localparam int EVT_W = 4;
  localparam int CNT_W = 48;
  localparam int CFG_W = pec_pkg::CFG_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_valid = 1'b0;
  logic [CFG_W-1:0] cfg_data = '0;
  logic             cnt_wr_valid = 1'b0;
  logic [CNT_W-1:0] cnt_wr_data = '0;
  logic [EVT_W-1:0] evt_count = '0;
  logic [1:0]       priv_lvl = '0;
  logic [CNT_W-1:0] cnt_value;
  logic             overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [CFG_W-1:0] m_cfg  = '0;
  logic             m_prev = 1'b0;
  logic [CNT_W-1:0] m_acc  = '0;
  logic             m_ovf  = 1'b0;

  always #5 clk = ~clk;

  perf_event_counter #(.EVT_W(EVT_W), .CNT_W(CNT_W)) u_perf_event_counter (
    .clk, .rst, .cfg_valid, .cfg_data, .cnt_wr_valid, .cnt_wr_data,
    .evt_count, .priv_lvl, .cnt_value, .overflow
  );

  function automatic logic [CFG_W-1:0] mk_cfg(input logic [7:0] thr, input bit en,
      input bit inv, input bit edg, input bit kern, input bit user);
    return {thr, en, inv, edg, kern, user};
  endfunction

  function automatic bit f_elig(input logic [CFG_W-1:0] c, input logic [1:0] p);
    return c[4] && ((p == 2'd0) ? c[1] : c[0]);
  endfunction

  function automatic bit f_lvl(input logic [CFG_W-1:0] c, input logic [EVT_W-1:0] e);
    bit met;
    met = (c[12:5] == 8'd0) ? (e != 0) : ({4'd0, e} >= c[12:5]);
    return met ^ c[3];
  endfunction

  function automatic logic [EVT_W-1:0] f_inc(input logic [CFG_W-1:0] c,
      input logic [EVT_W-1:0] e, input logic [1:0] p, input bit prev);
    if (!f_elig(c, p)) return '0;
    if (c[2]) return (c[12:5] != 0 && f_lvl(c, e) && !prev) ? 4'd1 : 4'd0;
    if (c[12:5] == 0 && !c[3]) return e;
    return f_lvl(c, e) ? 4'd1 : 4'd0;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (cnt_value !== m_acc || overflow !== m_ovf) begin
      fails++;
      $display("FAIL %s: cnt=%0h ovf=%0b expected cnt=%0h ovf=%0b",
               tag, cnt_value, overflow, m_acc, m_ovf);
    end
  endtask

  task automatic step(input bit cv, input logic [CFG_W-1:0] cd, input bit wv,
      input logic [CNT_W-1:0] wd, input logic [EVT_W-1:0] ev, input logic [1:0] pv,
      input string tag);
    logic [CNT_W:0] s;
    @(negedge clk);
    cfg_valid = cv; cfg_data = cd; cnt_wr_valid = wv; cnt_wr_data = wd;
    evt_count = ev; priv_lvl = pv;
    @(posedge clk);
    s = {1'b0, m_acc} + {{(CNT_W - EVT_W + 1){1'b0}}, f_inc(m_cfg, ev, pv, m_prev)};
    if (wv) begin m_acc = wd; m_ovf = 1'b0; end
    else begin m_acc = s[CNT_W-1:0]; m_ovf = m_ovf | s[CNT_W]; end
    m_prev = (cv || !m_cfg[4]) ? 1'b0 : (f_elig(m_cfg, pv) && f_lvl(m_cfg, ev));
    if (cv) m_cfg = cd;
    #1;
    compare(tag);
  endtask

  task automatic cfg(input logic [CFG_W-1:0] c, input string tag);
    step(1'b1, c, 1'b0, '0, 4'd0, 2'd0, tag);
  endtask

  task automatic ev(input logic [EVT_W-1:0] e, input logic [1:0] p, input string tag);
    step(1'b0, '0, 1'b0, '0, e, p, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: cnt=%0h ovf=%0b expected run to end", cnt_value, overflow);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    compare("R1 reset state");
    ev(4'd15, 2'd0, "R1 idle config"); ev(4'd9, 2'd3, "R1 idle config");

    cfg(mk_cfg(8'd0, 1, 0, 0, 0, 1), "R2 cfg");
    ev(4'd5, 2'd3, "R4 R2 user raw"); ev(4'd6, 2'd0, "R2 level 0 blocked");
    ev(4'd7, 2'd2, "R4 R2 user raw"); ev(4'd1, 2'd1, "R2 level 1");

    cfg(mk_cfg(8'd0, 1, 0, 0, 1, 0), "R3 cfg");
    ev(4'd3, 2'd0, "R3 kernel raw"); ev(4'd8, 2'd1, "R3 user blocked");

    cfg(mk_cfg(8'd4, 1, 0, 0, 1, 1), "R5 cfg");
    ev(4'd4, 2'd0, "R5 equal"); ev(4'd3, 2'd1, "R5 below"); ev(4'd15, 2'd2, "R5 above");

    cfg(mk_cfg(8'd4, 1, 1, 0, 1, 1), "R6 cfg");
    ev(4'd3, 2'd0, "R6 invert below"); ev(4'd5, 2'd3, "R6 invert above");
    cfg(mk_cfg(8'd0, 1, 1, 0, 1, 1), "R6 cfg zero");
    ev(4'd0, 2'd0, "R6 invert none"); ev(4'd2, 2'd0, "R6 invert some");

    cfg(mk_cfg(8'd2, 1, 0, 1, 1, 1), "R7 cfg");
    ev(4'd2, 2'd1, "R7 first rise"); ev(4'd3, 2'd1, "R7 held");
    ev(4'd0, 2'd1, "R7 fall"); ev(4'd2, 2'd1, "R7 second rise");
    cfg(mk_cfg(8'd2, 1, 0, 1, 1, 1), "R7 rewrite clears");
    ev(4'd9, 2'd0, "R7 rise after rewrite");

    cfg(mk_cfg(8'd0, 1, 0, 1, 1, 1), "R8 cfg");
    ev(4'd5, 2'd0, "R8 edge mask 0"); ev(4'd0, 2'd0, "R8"); ev(4'd5, 2'd2, "R8");

    cfg(mk_cfg(8'd0, 0, 0, 0, 1, 1), "R9 cfg");
    ev(4'd9, 2'd0, "R9 disabled"); ev(4'd9, 2'd3, "R9 disabled");

    cfg(mk_cfg(8'd0, 1, 0, 0, 1, 1), "R10 cfg");
    step(1'b0, '0, 1'b1, 48'h1234_5678_9ABC, 4'd7, 2'd0, "R10 load beats increment");
    ev(4'd1, 2'd0, "R10 count after load");

    step(1'b0, '0, 1'b1, 48'hFFFF_FFFF_FFFD, 4'd0, 2'd0, "R11 preload");
    ev(4'd5, 2'd3, "R11 wrap"); ev(4'd2, 2'd3, "R11 sticky");
    step(1'b0, '0, 1'b1, 48'd10, 4'd0, 2'd0, "R10 load clears overflow");

    void'($urandom(32'd2024));
    for (int i = 0; i < 3000; i++) begin
      bit cv, wv;
      logic [CFG_W-1:0] cd;
      logic [CNT_W-1:0] wd;
      cv = ($urandom() % 16) == 0;
      wv = ($urandom() % 40) == 0;
      cd = CFG_W'($urandom());
      if (($urandom() % 2) == 0) cd[12:5] = 8'($urandom() % 6);
      wd = {16'hFFFF, $urandom()};
      if (($urandom() % 3) == 0) wd = CNT_W'($urandom());
      step(cv, cd, wv, wd, EVT_W'($urandom()), 2'($urandom()), "RANDOM");
    end
    finish_run();
  end

endmodule